// File: doc/BRIEF.md
# Chip-Selected Parallel/Serial Shift Register

This block is a 16-stage register that either captures a parallel word or moves data one stage at a time. Data enters serially at the least significant stage and leaves from the most significant stage. All register activity is tied to the high-to-low transition of a slow shift clock input. The block samples that input, together with every other input, on a free-running system clock that runs faster than the shift clock. When the shift clock is seen going from high to low, the select and mode inputs chosen for that edge decide the action: hold, parallel capture, or one shift step.

An active-low select gates every operation. While it is high, the stages keep their contents whatever the mode input is. A protocol monitor watches for the select going high while the shift clock is high, because that order can clock the register falsely. When it sees this, it raises a sticky flag that only reset clears.

The serial path is a plain pin-level stream with no valid/ready handshake and no back-pressure. One bit moves per observed shift-clock fall, and the consumer must sample the serial output between falls. All inputs must be synchronous to the system clock.

Top module: `pss_shift_reg`

## Requirements
- R1: While the active-high synchronous reset is sampled high, all 16 stages clear to zero and the violation flag clears to 0. The serial output therefore reads 0 from the next system cycle.
- R2: The stages change only on the system edge at which the shift clock is sampled low after being sampled high on the previous edge. A rise of the shift clock, or a shift clock that stays steady, leaves every stage unchanged.
- R3: When the select (active low) is high at a shift-clock fall, no stage changes, whether the mode input is 1 or 0.
- R4: When the select is low and the mode input is 1 at a shift-clock fall, stage i takes parallel input bit i, for i = 0 to 15.
- R5: When the select is low and the mode input is 0 at a shift-clock fall, stage 0 takes the serial input and stage i takes the old value of stage i-1.
- R6: The serial output always equals stage 15. It changes on the system cycle after the edge that updates the register.
- R7: The violation flag sets when the select is sampled rising from 0 to 1 while the shift clock is sampled high. Once set, it stays at 1 until reset. A select rise while the shift clock is low does not set it.
- R8: After a parallel capture of word P, followed by 16 shift steps with the serial input at 0, the serial output presents P[15], P[14], ..., P[0] in that order, and the register then holds all zeros.
- R9: The mode input matters only at a shift-clock fall. Toggling it between falls has no effect, and the next fall uses the value present at that fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_clk | input | 1 | Slow shift clock; its falls trigger actions |
| sel_n | input | 1 | Select, active low; high means hold |
| load_mode | input | 1 | 1 = parallel capture, 0 = shift step |
| par_in | input | 16 | Parallel word; bit i goes to stage i |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Stage 15 |
| viol | output | 1 | Sticky flag for a select rise while the shift clock is high |

## Verification
Assertions check the following on every cycle:
- the reset clear;
- that the serial output is stable except after a sampled shift-clock fall;
- the exact register contents after hold, capture and shift steps;
- that the violation flag sets and then stays set.

Only the bench's scenarios can show the end-to-end behaviour. This covers the full drain order of a captured word, mode toggles between falls being ignored, and held contents surviving a deselected fall. The bench shows held contents by shifting them out afterwards.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int unsigned PSS_DEF_WIDTH = 16;

  typedef enum logic [1:0] {
    PSS_OP_HOLD  = 2'd0,
    PSS_OP_LOAD  = 2'd1,
    PSS_OP_SHIFT = 2'd2
  } pss_op_e;

  function automatic pss_op_e pss_decode(input logic fall, input logic sel_n,
                                         input logic load_mode);
    if (!fall || sel_n) return PSS_OP_HOLD;
    else if (load_mode) return PSS_OP_LOAD;
    else return PSS_OP_SHIFT;
  endfunction
endpackage

// File: rtl/pss_edge_track.sv
module pss_edge_track (
  input  logic clk,
  input  logic rst,
  input  logic shift_clk,
  input  logic sel_n,
  output logic sclk_fall,
  output logic sel_rise_hi
);
  logic prev_sclk;
  logic prev_sel_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sclk  <= 1'b0;
      prev_sel_n <= 1'b1;
    end else begin
      prev_sclk  <= shift_clk;
      prev_sel_n <= sel_n;
    end
  end

  assign sclk_fall   = prev_sclk & ~shift_clk;
  assign sel_rise_hi = ~prev_sel_n & sel_n & shift_clk;

  a_r2_fall_needs_prior_high: assert property (@(posedge clk) disable iff (rst)
    sclk_fall |-> ($past(shift_clk) && !shift_clk));
endmodule

// File: rtl/pss_stage_bank.sv
module pss_stage_bank #(
  parameter int unsigned WIDTH = pss_pkg::PSS_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  pss_pkg::pss_op_e op,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  import pss_pkg::*;

  logic [WIDTH-1:0] shift_src;
  assign shift_src[0] = ser_in;

  for (genvar i = 1; i < WIDTH; i++) begin : g_link
    assign shift_src[i] = q[i-1];
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else begin
        unique case (op)
          PSS_OP_LOAD:  q[i] <= par_in[i];
          PSS_OP_SHIFT: q[i] <= shift_src[i];
          default:      q[i] <= q[i];
        endcase
      end
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (q == '0));
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (op == PSS_OP_HOLD) |=> $stable(q));
  a_r4_load_word: assert property (@(posedge clk) disable iff (rst)
    (op == PSS_OP_LOAD) |=> (q == $past(par_in)));
  a_r5_shift_step: assert property (@(posedge clk) disable iff (rst)
    (op == PSS_OP_SHIFT) |=> (q[0] == $past(ser_in) &&
                              q[WIDTH-1:1] == $past(q[WIDTH-2:0])));
endmodule

// File: rtl/pss_viol_mon.sv
module pss_viol_mon (
  input  logic clk,
  input  logic rst,
  input  logic sel_rise_hi,
  output logic viol
);
  always_ff @(posedge clk) begin
    if (rst) viol <= 1'b0;
    else if (sel_rise_hi) viol <= 1'b1;
  end

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    viol |=> viol);
  a_r1_flag_clear: assert property (@(posedge clk)
    rst |=> !viol);
endmodule

// File: rtl/pss_shift_reg.sv
module pss_shift_reg #(
  parameter int unsigned WIDTH = pss_pkg::PSS_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_clk,
  input  logic             sel_n,
  input  logic             load_mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             viol
);
  import pss_pkg::*;

  localparam int unsigned TOP = WIDTH - 1;

  logic             sclk_fall;
  logic             sel_rise_hi;
  pss_op_e          op;
  logic [WIDTH-1:0] q;

  pss_edge_track u_edge (
    .clk         (clk),
    .rst         (rst),
    .shift_clk   (shift_clk),
    .sel_n       (sel_n),
    .sclk_fall   (sclk_fall),
    .sel_rise_hi (sel_rise_hi)
  );

  assign op = pss_decode(sclk_fall, sel_n, load_mode);

  pss_stage_bank #(.WIDTH(WIDTH)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .par_in (par_in),
    .ser_in (ser_in),
    .q      (q)
  );

  pss_viol_mon u_mon (
    .clk         (clk),
    .rst         (rst),
    .sel_rise_hi (sel_rise_hi),
    .viol        (viol)
  );

  assign ser_out = q[TOP];

  a_r2_quiet_without_fall: assert property (@(posedge clk) disable iff (rst)
    !$fell(shift_clk) |=> $stable(ser_out));
  a_r7_flag_on_bad_rise: assert property (@(posedge clk) disable iff (rst)
    ($rose(sel_n) && shift_clk) |=> viol);
endmodule

// File: tb/sim_pss_shift_reg.sv
module sim_pss_shift_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_clk = 1'b0;
  logic sel_n = 1'b1;
  logic load_mode = 1'b0;
  logic [15:0] par_in = '0;
  logic ser_in = 1'b0;
  logic ser_out;
  logic viol;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pss_shift_reg u0 (
    .clk(clk), .rst(rst), .shift_clk(shift_clk), .sel_n(sel_n),
    .load_mode(load_mode), .par_in(par_in), .ser_in(ser_in),
    .ser_out(ser_out), .viol(viol)
  );

  // Behavioural reference: queue of bits, index 0 is stage 0.
  bit mq[$];
  bit m_viol;
  bit m_prev_clk;
  bit m_prev_sel;

  initial begin
    for (int i = 0; i < 16; i++) mq.push_back(1'b0);
    m_viol = 0; m_prev_clk = 0; m_prev_sel = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      foreach (mq[i]) mq[i] = 1'b0;
      m_viol = 0; m_prev_clk = 0; m_prev_sel = 1;
    end else begin
      if (!m_prev_sel && sel_n && shift_clk) m_viol = 1;
      if (m_prev_clk && !shift_clk && !sel_n) begin
        if (load_mode) begin
          for (int i = 0; i < 16; i++) mq[i] = par_in[i];
        end else begin
          void'(mq.pop_back());
          mq.push_front(ser_in);
        end
      end
      m_prev_clk = shift_clk;
      m_prev_sel = sel_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model (R6 serial output, R7 flag).
  always @(negedge clk) begin
    if (!rst) begin
      chk(ser_out == mq[15], "R6 per-cycle ser_out", ser_out, mq[15]);
      chk(viol == m_viol, "R7 per-cycle viol", viol, m_viol);
    end
  end

  task automatic pulse();
    @(negedge clk) shift_clk = 1'b1;
    @(negedge clk);
    @(negedge clk) shift_clk = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load_word(input logic [15:0] w);
    sel_n = 1'b0; load_mode = 1'b1; par_in = w;
    pulse();
  endtask

  task automatic drain(output logic [15:0] got);
    sel_n = 1'b0; load_mode = 1'b0; ser_in = 1'b0;
    for (int k = 15; k >= 0; k--) begin
      got[k] = ser_out;
      pulse();
    end
  endtask

  initial begin
    logic [15:0] got;
    repeat (3) @(negedge clk);
    chk(ser_out == 1'b0 && viol == 1'b0, "R1 reset state", {ser_out, viol}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R4 + R8: capture then drain MSB first, register ends zero
    load_word(16'hA5C3);
    chk(ser_out == 1'b1, "R4 stage15 after capture", ser_out, 1);
    drain(got);
    chk(got == 16'hA5C3, "R8 drain order", got, 16'hA5C3);
    drain(got);
    chk(got == 16'h0000, "R8 register empty after drain", got, 0);

    // R5: serial fill pattern then read back
    sel_n = 1'b0; load_mode = 1'b0;
    for (int k = 15; k >= 0; k--) begin
      ser_in = (16'h3C96 >> k) & 1;
      pulse();
    end
    drain(got);
    chk(got == 16'h3C96, "R5 serial fill", got, 16'h3C96);

    // R3: deselected falls in both modes keep contents
    load_word(16'h1234);
    sel_n = 1'b1; load_mode = 1'b1; par_in = 16'hFFFF; pulse();
    load_mode = 1'b0; ser_in = 1'b1; pulse();
    drain(got);
    chk(got == 16'h1234, "R3 hold while deselected", got, 16'h1234);

    // R2: shift clock rise only and steady levels do nothing
    load_word(16'h8001);
    sel_n = 1'b0; load_mode = 1'b0; ser_in = 1'b1;
    @(negedge clk) shift_clk = 1'b1;
    repeat (4) @(negedge clk);
    chk(ser_out == 1'b1, "R2 no action on rise", ser_out, 1);
    load_mode = 1'b1; par_in = 16'h0000;
    repeat (3) @(negedge clk);
    chk(ser_out == 1'b1, "R2 no action while high", ser_out, 1);
    @(negedge clk) shift_clk = 1'b0; load_mode = 1'b0; ser_in = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(ser_out == 1'b0, "R2 step on fall", ser_out, 0);
    drain(got);
    chk(got == 16'h0002, "R2 content after single step", got, 16'h0002);

    // R9: mode toggles between falls are ignored
    load_word(16'h00F0);
    @(negedge clk) load_mode = 1'b1; par_in = 16'hFFFF;
    @(negedge clk) load_mode = 1'b0;
    ser_in = 1'b0; pulse();
    drain(got);
    chk(got == 16'h01E0, "R9 mode at fall only", got, 16'h01E0);

    // R7: clean rise (clock low) leaves flag clear, bad rise sets it
    sel_n = 1'b0; @(negedge clk);
    sel_n = 1'b1; @(negedge clk); @(negedge clk);
    chk(viol == 1'b0, "R7 clean select rise", viol, 0);
    sel_n = 1'b0; shift_clk = 1'b1; @(negedge clk);
    sel_n = 1'b1; @(negedge clk); @(negedge clk);
    chk(viol == 1'b1, "R7 bad select rise", viol, 1);
    shift_clk = 1'b0; repeat (5) @(negedge clk);
    chk(viol == 1'b1, "R7 flag sticky", viol, 1);

    // R1: reset clears flag and stages
    load_word(16'hFFFF);
    rst = 1'b1; repeat (2) @(negedge clk);
    chk(ser_out == 1'b0 && viol == 1'b0, "R1 reset clears", {ser_out, viol}, 0);
    rst = 1'b0; @(negedge clk);
    drain(got);
    chk(got == 16'h0000, "R1 stages zero after reset", got, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule